// File: doc/BRIEF.md
# Variable-size 2D Hadamard transform for an 8x8 block

This block takes one 8x8 block of unsigned pixels and returns its integer Hadamard coefficients. The pixels arrive in nested quadrant order. A side input gives the transform size of each 4x4 quadrant. Every 2x2 sub-block always goes through a 2x2 Hadamard step. When a quadrant is coded 4x4, a second pass combines its four sub-blocks. When the whole block is coded 8x8, a third pass combines the four quadrants. Each larger pass takes the coefficients that share a position in the smaller results and puts them through the same 2x2 sum/difference kernel. No full 4x4 or 8x8 matrix product is ever formed.

The arithmetic uses plain sums and differences with no scaling, so the result is exactly invertible. Normalization is left to downstream stages, which know the block size. Pixels are accepted on a valid/ready stream until all 64 are in. The block then runs two internal passes of fixed length. After that it streams the 64 signed coefficients out on a second valid/ready stream, with a last flag on the final one.

Top module: `vhad_transform`

## Requirements
- R1: After reset, `in_ready_o` is 1 and `out_valid_o` is 0. `in_ready_o` stays high until exactly 64 pixels have been accepted. It then stays low until the output handshake that carries coefficient 63, and it is 1 again in the next cycle.
- R2: Every 2x2 sub-block is transformed with sign (-1)^popcount(u&v) between output position u and input position v. Positions are 2-bit codes: bit 1 is the row and bit 0 is the column. A quadrant with size code 2'b00 gets only this step.
- R3: In a quadrant with code 2'b01, and in a quadrant with code 2'b10 when not all four codes are 2'b10, the four sub-blocks are then combined. Output index o within the quadrant gets the sum over inputs i of (-1)^popcount(o&i&4'hF)·x[i].
- R4: When all four quadrant codes are 2'b10, a third step combines the quadrants. Output index o gets the sum over all 64 inputs i of (-1)^popcount(o&i)·x[i].
- R5: The size code is sampled only with the pixels at indices 0, 16, 32 and 48. Its value with any other pixel has no effect on the output. Code 2'b11 acts as 2'b00.
- R6: Inputs and outputs use the same 6-bit index. Bits [5:4] select the quadrant (0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right). Bits [3:2] select the 2x2 sub-block inside the quadrant, in the same order. Bits [1:0] select the position inside the sub-block.
- R7: Coefficients leave in index order 0 to 63. While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_coef_o` holds its value. `out_last_o` is high only with coefficient 63.
- R8: `out_valid_o` rises exactly 32 clock cycles after the edge that accepts pixel 63.
- R9: Coefficients are exact two's-complement integers of width PIX_W+7, with no scaling or saturation. A block of all 255 coded 8x8 gives 16320 at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Pixel valid |
| in_ready_o | output | 1 | Pixel accepted when high with valid |
| in_pix_i | input | PIX_W | Unsigned pixel |
| in_size_i | input | 2 | Quadrant size code, sampled with the first pixel of each quadrant |
| out_valid_o | output | 1 | Coefficient valid |
| out_ready_i | input | 1 | Downstream ready |
| out_coef_o | output | PIX_W+7 | Signed coefficient |
| out_last_o | output | 1 | Marks coefficient 63 |

## Verification
The embedded assertions check the stream protocol on every cycle. They cover the input closing after the 64th pixel and reopening after the last output, coefficients held steady under backpressure, the last flag appearing only with valid data, and the fixed 32-cycle gap between input and output. The arithmetic can only be shown by the bench's scenarios. These compare each coefficient against a reference sign-sum for every mix of size codes, with noise on the unsampled size inputs, impulse and full-scale blocks, and random stalls on both streams.

// File: rtl/hvt_pkg.sv
package hvt_pkg;
  localparam int COEF_N = 64;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;

  localparam logic [1:0] SZ_2X2 = 2'b00;
  localparam logic [1:0] SZ_4X4 = 2'b01;
  localparam logic [1:0] SZ_8X8 = 2'b10;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_STG4 = 2'd1,
    PH_STG8 = 2'd2,
    PH_EMIT = 2'd3
  } phase_e;
endpackage

// File: rtl/hvt_bfly.sv
// 2x2 sum/difference kernel applied along rows then columns.
module hvt_bfly #(
  parameter int W = 15
) (
  input  logic [3:0][W-1:0] a_i,
  output logic [3:0][W-1:0] y_o
);
  logic [W-1:0] s0, d0, s1, d1;

  always_comb begin
    s0 = a_i[0] + a_i[1];
    d0 = a_i[0] - a_i[1];
    s1 = a_i[2] + a_i[3];
    d1 = a_i[2] - a_i[3];
    y_o[0] = s0 + s1;
    y_o[1] = d0 + d1;
    y_o[2] = s0 - s1;
    y_o[3] = d0 - d1;
  end
endmodule

// File: rtl/hvt_coef_store.sv
module hvt_coef_store #(
  parameter int W     = 15,
  parameter int DEPTH = 64,
  parameter int LN    = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [LN-1:0][AW-1:0] addr_i,
  input  logic [LN-1:0][W-1:0]  wr_data_i,
  output logic [LN-1:0][W-1:0]  rd_data_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (wr_en_i) begin
      for (int l = 0; l < LN; l++) mem_q[addr_i[l]] <= wr_data_i[l];
    end
  end

  for (genvar l = 0; l < LN; l++) begin : g_rd
    assign rd_data_o[l] = mem_q[addr_i[l]];
  end
endmodule

// File: rtl/hvt_sequencer.sv
module hvt_sequencer
  import hvt_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic [1:0]                in_size_i,
  input  logic                      out_ready_i,
  output logic                      in_ready_o,
  output logic                      accept_o,
  output logic [1:0]                pix_slot_o,
  output logic                      load_sel_o,
  output logic                      wr_en_o,
  output logic [LANES-1:0][ADDR_W-1:0] addr_o,
  output logic                      out_valid_o,
  output logic                      out_last_o
);
  phase_e            phase_q;
  logic [ADDR_W-1:0] cnt_q;
  logic [3:0][1:0]   qsize_q;
  logic              all8;
  logic              q_wide;

  assign in_ready_o  = (phase_q == PH_LOAD);
  assign accept_o    = in_ready_o && in_valid_i;
  assign out_valid_o = (phase_q == PH_EMIT);
  assign out_last_o  = out_valid_o && (cnt_q == ADDR_W'(COEF_N - 1));
  assign pix_slot_o  = cnt_q[1:0];
  assign load_sel_o  = (phase_q == PH_LOAD);

  assign all8   = (qsize_q[0] == SZ_8X8) && (qsize_q[1] == SZ_8X8) &&
                  (qsize_q[2] == SZ_8X8) && (qsize_q[3] == SZ_8X8);
  assign q_wide = (qsize_q[cnt_q[3:2]] == SZ_4X4) || (qsize_q[cnt_q[3:2]] == SZ_8X8);

  always_comb begin
    unique case (phase_q)
      PH_LOAD: wr_en_o = accept_o && (cnt_q[1:0] == 2'd3);
      PH_STG4: wr_en_o = q_wide;
      PH_STG8: wr_en_o = all8;
      default: wr_en_o = 1'b0;
    endcase
  end

  // Lane n gathers the co-located coefficient of sub-unit n for the current op.
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    localparam logic [1:0] LN_ID = 2'(n);
    always_comb begin
      unique case (phase_q)
        PH_LOAD: addr_o[n] = {cnt_q[5:2], LN_ID};
        PH_STG4: addr_o[n] = {cnt_q[3:2], LN_ID, cnt_q[1:0]};
        PH_STG8: addr_o[n] = {LN_ID, cnt_q[3:0]};
        default: addr_o[n] = (n == 0) ? cnt_q : '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      qsize_q <= '0;
    end else begin
      unique case (phase_q)
        PH_LOAD: begin
          if (accept_o) begin
            if (cnt_q[3:0] == 4'd0) qsize_q[cnt_q[5:4]] <= in_size_i;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == ADDR_W'(COEF_N - 1)) phase_q <= PH_STG4;
          end
        end
        PH_STG4: begin
          if (cnt_q[3:0] == 4'd15) begin
            phase_q <= PH_STG8;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_STG8: begin
          if (cnt_q[3:0] == 4'd15) begin
            phase_q <= PH_EMIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (out_ready_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == ADDR_W'(COEF_N - 1)) phase_q <= PH_LOAD;
          end
        end
      endcase
    end
  end

  assert_block_close_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && cnt_q == ADDR_W'(COEF_N - 1)) |=> !in_ready_o && !out_valid_o);

  assert_reopen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> in_ready_o);
endmodule

// File: rtl/vhad_transform.sv
module vhad_transform
  import hvt_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = PIX_W + 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PIX_W-1:0]  in_pix_i,
  input  logic [1:0]        in_size_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [COEF_W-1:0] out_coef_o,
  output logic              out_last_o
);
  localparam int EXT_W = COEF_W - PIX_W;

  logic                           accept;
  logic [1:0]                     pix_slot;
  logic                           load_sel;
  logic                           wr_en;
  logic [LANES-1:0][ADDR_W-1:0]   addr;
  logic [LANES-1:0][COEF_W-1:0]   rd_data;
  logic [LANES-1:0][COEF_W-1:0]   bf_in;
  logic [LANES-1:0][COEF_W-1:0]   bf_out;
  logic [2:0][PIX_W-1:0]          hold_q;

  hvt_sequencer u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_size_i   (in_size_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .accept_o    (accept),
    .pix_slot_o  (pix_slot),
    .load_sel_o  (load_sel),
    .wr_en_o     (wr_en),
    .addr_o      (addr),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o)
  );

  // First three pixels of a sub-block wait here; the fourth goes straight in.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (accept && pix_slot != 2'd3) begin
      hold_q[pix_slot] <= in_pix_i;
    end
  end

  always_comb begin
    if (load_sel) begin
      bf_in[0] = {{EXT_W{1'b0}}, hold_q[0]};
      bf_in[1] = {{EXT_W{1'b0}}, hold_q[1]};
      bf_in[2] = {{EXT_W{1'b0}}, hold_q[2]};
      bf_in[3] = {{EXT_W{1'b0}}, in_pix_i};
    end else begin
      bf_in = rd_data;
    end
  end

  hvt_bfly #(.W(COEF_W)) u_bfly (
    .a_i (bf_in),
    .y_o (bf_out)
  );

  hvt_coef_store #(.W(COEF_W), .DEPTH(COEF_N), .LN(LANES), .AW(ADDR_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (bf_out),
    .rd_data_o (rd_data)
  );

  assign out_coef_o = rd_data[0];

  // Checker-side gap counter for the fixed processing window.
  logic [5:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        gap_q <= '0;
    else if (!in_ready_o && !out_valid_o) gap_q <= gap_q + 1'b1;
    else                                gap_q <= '0;
  end

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> gap_q == 6'd32);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_coef_o) && $stable(out_last_o));

  assert_last_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));
endmodule

// File: tb/vhad_transform_test.sv
`timescale 1ns/1ps
module vhad_transform_test;
  localparam int PIX_W  = 8;
  localparam int COEF_W = PIX_W + 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [PIX_W-1:0]  in_pix = '0;
  logic [1:0]        in_size = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [COEF_W-1:0] out_coef;
  logic              out_last;

  always #4 clk = ~clk;

  vhad_transform #(.PIX_W(PIX_W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_pix_i    (in_pix),
    .in_size_i   (in_size),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_coef_o  (out_coef),
    .out_last_o  (out_last)
  );

  int    checks = 0;
  int    errors = 0;
  int    exp_q[$];
  string tag_q[$];
  int    blk[64];
  logic [1:0] cod[4];
  int    out_idx = 0;
  bit    mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Reference: signed sum over the index bits the selected stages cover.
  task automatic run_block(input bit gaps, input string force_tag);
    bit all8;
    int lat;
    all8 = 1'b1;
    for (int q = 0; q < 4; q++) if (cod[q] != 2'b10) all8 = 1'b0;
    for (int o = 0; o < 64; o++) begin
      int m;
      int acc;
      string t;
      logic [1:0] c;
      c = cod[o >> 4];
      if (all8) begin m = 63; t = "R4"; end
      else if (c == 2'b01 || c == 2'b10) begin m = 15; t = "R3"; end
      else begin m = 3; t = "R2"; end
      acc = 0;
      for (int i = 0; i < 64; i++) begin
        if ((i & ~m) == (o & ~m)) begin
          if ($countones(i & o & m) % 2 == 1) acc -= blk[i];
          else acc += blk[i];
        end
      end
      exp_q.push_back(acc);
      tag_q.push_back(force_tag != "" ? force_tag : t);
    end
    for (int i = 0; i < 64; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_pix   = PIX_W'(blk[i]);
      in_size  = (i % 16 == 0) ? cod[i / 16] : 2'($urandom);  // R5: noise elsewhere
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(!in_ready, "R1", "in_ready after 64 pixels", int'(in_ready), 0);
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 32, "R8", "cycles to first coefficient", lat, 32);
  endtask

  // Monitor: scoreboard pop and compare, random backpressure.
  initial begin
    bit               stall_prev;
    logic [COEF_W-1:0] coef_prev;
    stall_prev = 1'b0;
    coef_prev  = '0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (stall_prev)
          check(out_valid && out_coef == coef_prev, "R7", "held under stall",
                int'($signed(out_coef)), int'($signed(coef_prev)));
        out_ready = ($urandom % 3 != 0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected coefficient", out_idx, -1);
          end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(int'($signed(out_coef)) == e, t, $sformatf("coef %0d", out_idx % 64),
                  int'($signed(out_coef)), e);
          end
          check(out_last == (out_idx % 64 == 63), "R7", "last flag",
                int'(out_last), int'(out_idx % 64 == 63));
          check(!in_ready, "R1", "input closed while emitting", int'(in_ready), 0);
          out_idx++;
        end
        stall_prev = out_valid && !out_ready;
        coef_prev  = out_coef;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready idle", int'(in_ready), 1);
    mon_on = 1'b1;

    // Zero block, all 2x2
    for (int i = 0; i < 64; i++) blk[i] = 0;
    for (int q = 0; q < 4; q++) cod[q] = 2'b00;
    run_block(1'b0, "R2");

    // Full scale, whole-block transform: DC must reach 16320
    for (int i = 0; i < 64; i++) blk[i] = 255;
    for (int q = 0; q < 4; q++) cod[q] = 2'b10;
    run_block(1'b0, "R9");

    // Ramp, all quadrants 4x4
    for (int i = 0; i < 64; i++) blk[i] = i;
    for (int q = 0; q < 4; q++) cod[q] = 2'b01;
    run_block(1'b1, "R3");

    // Impulse at index 5, 2x2 only: only indices 4..7 nonzero
    for (int i = 0; i < 64; i++) blk[i] = (i == 5) ? 200 : 0;
    for (int q = 0; q < 4; q++) cod[q] = 2'b00;
    run_block(1'b0, "R6");

    // Random, whole-block 8x8
    for (int i = 0; i < 64; i++) blk[i] = int'($urandom % 256);
    for (int q = 0; q < 4; q++) cod[q] = 2'b10;
    run_block(1'b1, "R4");

    // Mixed codes incl. 2'b11 acting as 2x2
    for (int i = 0; i < 64; i++) blk[i] = int'($urandom % 256);
    cod[0] = 2'b00; cod[1] = 2'b01; cod[2] = 2'b10; cod[3] = 2'b11;
    run_block(1'b1, "R5");

    // Three 8x8 codes plus one 4x4: 8x8 quadrants fall back to 4x4
    for (int i = 0; i < 64; i++) blk[i] = int'($urandom % 256);
    cod[0] = 2'b10; cod[1] = 2'b10; cod[2] = 2'b10; cod[3] = 2'b01;
    run_block(1'b0, "R3");

    // Checkerboard extremes, 8x8
    for (int i = 0; i < 64; i++) blk[i] = ((i ^ (i >> 1)) & 1) ? 255 : 0;
    for (int q = 0; q < 4; q++) cod[q] = 2'b10;
    run_block(1'b1, "R4");

    // Random pixels and codes
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 64; i++) blk[i] = int'($urandom % 256);
      for (int q = 0; q < 4; q++) cod[q] = (b % 3 == 0) ? 2'b10 : 2'($urandom);
      run_block(b[0], "");
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1, "R1", "input reopened after last", int'(in_ready), 1);
    check(out_idx == 14 * 64, "R7", "coefficient count", out_idx, 14 * 64);
    finish_run();
  end
endmodule